// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is the counting core of a real-time clock. Each cycle in which the one-second tick input is high and counting is enabled, it advances a packed-BCD time of day and a calendar date. The time covers seconds, minutes, hours and a weekday. The date covers day of month, month, a two-digit year and a one-bit century. Software-side logic elsewhere loads the time and the date through two set words. The running values are read back as two 32-bit words with fixed field positions.

Hours run either as 00..23 or as 01..12 with an AM/PM flag. The day of month rolls over at the real month length, and February gains a 29th day in years divisible by four. An alarm word holds second, minute, hour and day-of-month targets. Each target has its own compare enable, and the block pulses when all enabled fields start to match. A periodic update pulse can also be raised on every second or on every minute boundary.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the time word reads 0x8000_0000 and the date word reads 0x8000_0041 (00:00:00, weekday 0, day 01, month 01, year 00, century 0). Bit 31 of the time word stays 1 until a time load, and bit 31 of the date word stays 1 until a date load. Each bit then reads 0 until the next reset.
- R2: A time load takes seconds (BCD, set bits 6:0), minutes (13:7), hours (19:14), weekday (22:20) and PM (23). A date load takes day (5:0), month (10:6), year (18:11) and century (19). The same cycle makes those fields readable at the same positions. A load wins over a tick in the same cycle, and that tick is lost.
- R3: The count advances only on a cycle where tick_i and run_en_i are both 1. Otherwise both words hold.
- R4: Seconds and minutes step through decimal digits and wrap from 59 to 00. Each wrap carries into the next field.
- R5: With hr12_i at 0, hours wrap from 23 to 00, and that wrap advances the date by one day.
- R6: With hr12_i at 1, hours step 11 to 12 and toggle pm_o, and 12 steps to 01 with pm_o unchanged. The date advances only on the 11 to 12 step that clears pm_o (midnight).
- R7: The day of month wraps to 01 after 31 in months 1, 3, 5, 7, 8, 10 and 12, and after 30 in months 4, 6, 9 and 11. In February it wraps after 29 when the year is divisible by 4 and after 28 otherwise.
- R8: Month wraps from 12 to 01 and carries into the year. Year wraps from 99 to 00 and toggles the century bit.
- R9: The weekday (time word bits 22:20) counts 0..6 and advances by one on each day advance, wrapping 6 to 0.
- R10: Alarm set bits 26, 27, 28 and 29 enable comparison of seconds (6:0), minutes (13:7), hours (19:14) and day of month (25:20). On a tick with no load, alarm_pulse_o is high for one clock cycle, together with the new time, if all enabled fields match the new value and did not all match the old one. With no enable set it never pulses.
- R11: update_pulse_o is high for one clock cycle, together with the new time, after a counting tick while upd_en_i is 1. With upd_sec_i at 1 this happens on every such tick. With upd_sec_i at 0 it happens only when seconds become 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second tick, one cycle wide |
| run_en_i | input | 1 | Counting enable |
| hr12_i | input | 1 | 1: 12-hour format, 0: 24-hour format |
| upd_en_i | input | 1 | Periodic update pulse enable |
| upd_sec_i | input | 1 | 1: update every second, 0: every minute |
| time_load_i | input | 1 | Load the time set word |
| time_set_i | input | 24 | Time set word (PM, weekday, hours, minutes, seconds) |
| date_load_i | input | 1 | Load the date set word |
| date_set_i | input | 20 | Date set word (century, year, month, day) |
| alarm_set_i | input | 30 | Alarm targets and compare enables |
| time_word_o | output | 32 | Current time, bit 31 = invalid |
| date_word_o | output | 32 | Current date, bit 31 = invalid |
| pm_o | output | 1 | PM flag in 12-hour format |
| alarm_pulse_o | output | 1 | Alarm match pulse |
| update_pulse_o | output | 1 | Periodic update pulse |

## Verification
The hardest states to reach are the cascaded rollovers: 11:59:59 PM into midnight in 12-hour format, the last day of February in leap and common years, and 99 December 31 into a new century. Counting there from reset would take years of ticks. The stimulus instead loads the time and date a single tick short of each boundary, then ticks across it. The alarm's first-match rule is reached by placing the time just before a target and ticking through it and past it. This shows that a match held over several ticks pulses only once.

// File: rtl/bcdclk_pkg.sv
package bcdclk_pkg;

    localparam int SEC_LAST  = 59;
    localparam int MIN_LAST  = 59;
    localparam int H24_LAST  = 23;
    localparam int H12_LAST  = 12;
    localparam int MON_LAST  = 12;
    localparam int YEAR_LAST = 99;

    typedef struct packed {
        logic       pm;
        logic [1:0] hr_t;
        logic [3:0] hr_o;
        logic [2:0] min_t;
        logic [3:0] min_o;
        logic [2:0] sec_t;
        logic [3:0] sec_o;
    } clk_time_t;

    typedef struct packed {
        logic [2:0] wday;
        logic       cent;
        logic [3:0] yr_t;
        logic [3:0] yr_o;
        logic       mon_t;
        logic [3:0] mon_o;
        logic [1:0] day_t;
        logic [3:0] day_o;
    } clk_date_t;

    typedef struct packed {
        logic t_inv;
        logic d_inv;
        logic upd;
    } clk_top_t;

    localparam clk_date_t DATE_RST = '{wday: 3'd0, cent: 1'b0, yr_t: 4'd0, yr_o: 4'd0,
                                       mon_t: 1'b0, mon_o: 4'd1, day_t: 2'd0, day_o: 4'd1};

    function automatic logic [6:0] bcd2bin(input logic [7:0] b);
        return 7'(10 * int'(b[7:4]) + int'(b[3:0]));
    endfunction

    function automatic logic [7:0] bin2bcd(input logic [6:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    // days in a month; leap when the two-digit year is a multiple of four
    function automatic logic [6:0] month_len(input logic [6:0] mo, input logic [6:0] yr);
        logic [6:0] n;
        case (mo)
            7'd2:                        n = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:     n = 7'd30;
            default:                     n = 7'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bcdclk_time_ctr.sv
module bcdclk_time_ctr
    import bcdclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_i,
    input  logic        load_i,
    input  logic [20:0] set_i,     // {pm, hours, minutes, seconds}
    input  logic        hr12_i,
    output clk_time_t   time_q_o,
    output clk_time_t   time_d_o,
    output logic        sec_wrap_o,
    output logic        day_carry_o
);

    clk_time_t st_d, st_q;
    logic [6:0] s, m, h;
    logic [7:0] bs, bm, bh;
    logic       pm_n, wrap, carry;

    always_comb begin
        st_d  = st_q;
        wrap  = 1'b0;
        carry = 1'b0;
        s     = bcd2bin({1'b0, st_q.sec_t, st_q.sec_o});
        m     = bcd2bin({1'b0, st_q.min_t, st_q.min_o});
        h     = bcd2bin({2'b00, st_q.hr_t, st_q.hr_o});
        pm_n  = st_q.pm;
        if (!load_i && step_i) begin
            if (s >= 7'(SEC_LAST)) begin
                s    = 7'd0;
                wrap = 1'b1;
                if (m >= 7'(MIN_LAST)) begin
                    m = 7'd0;
                    if (hr12_i) begin
                        if (h >= 7'(H12_LAST)) begin
                            h = 7'd1;
                        end else if (h == 7'(H12_LAST - 1)) begin
                            h     = 7'(H12_LAST);
                            carry = st_q.pm;
                            pm_n  = ~st_q.pm;
                        end else begin
                            h = h + 7'd1;
                        end
                    end else begin
                        if (h >= 7'(H24_LAST)) begin
                            h     = 7'd0;
                            carry = 1'b1;
                        end else begin
                            h = h + 7'd1;
                        end
                    end
                end else begin
                    m = m + 7'd1;
                end
            end else begin
                s = s + 7'd1;
            end
        end
        bs = bin2bcd(s);
        bm = bin2bcd(m);
        bh = bin2bcd(h);
        if (load_i) begin
            st_d = clk_time_t'(set_i);
        end else if (step_i) begin
            st_d.sec_t = bs[6:4];
            st_d.sec_o = bs[3:0];
            st_d.min_t = bm[6:4];
            st_d.min_o = bm[3:0];
            st_d.hr_t  = bh[5:4];
            st_d.hr_o  = bh[3:0];
            st_d.pm    = pm_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign time_q_o    = st_q;
    assign time_d_o    = st_d;
    assign sec_wrap_o  = wrap;
    assign day_carry_o = carry;

endmodule

// File: rtl/bcdclk_date_ctr.sv
module bcdclk_date_ctr
    import bcdclk_pkg::*;
#(
    parameter int WEEK_LEN = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        carry_i,
    input  logic        load_i,
    input  logic [19:0] set_i,
    input  logic        wday_load_i,
    input  logic [2:0]  wday_i,
    output clk_date_t   date_q_o,
    output clk_date_t   date_d_o
);

    localparam logic [2:0] WDAY_LAST = 3'(WEEK_LEN - 1);

    clk_date_t  st_d, st_q;
    logic [6:0] d, mo, y;
    logic [7:0] bd, bmo, by;
    logic       c;

    always_comb begin
        st_d = st_q;
        d    = bcd2bin({2'b00, st_q.day_t, st_q.day_o});
        mo   = bcd2bin({3'b000, st_q.mon_t, st_q.mon_o});
        y    = bcd2bin({st_q.yr_t, st_q.yr_o});
        c    = st_q.cent;
        if (carry_i) begin
            if (d >= month_len(mo, y)) begin
                d = 7'd1;
                if (mo >= 7'(MON_LAST)) begin
                    mo = 7'd1;
                    if (y >= 7'(YEAR_LAST)) begin
                        y = 7'd0;
                        c = ~c;
                    end else begin
                        y = y + 7'd1;
                    end
                end else begin
                    mo = mo + 7'd1;
                end
            end else begin
                d = d + 7'd1;
            end
        end
        bd  = bin2bcd(d);
        bmo = bin2bcd(mo);
        by  = bin2bcd(y);
        if (load_i) begin
            st_d.cent  = set_i[19];
            st_d.yr_t  = set_i[18:15];
            st_d.yr_o  = set_i[14:11];
            st_d.mon_t = set_i[10];
            st_d.mon_o = set_i[9:6];
            st_d.day_t = set_i[5:4];
            st_d.day_o = set_i[3:0];
        end else if (carry_i) begin
            st_d.cent  = c;
            st_d.yr_t  = by[7:4];
            st_d.yr_o  = by[3:0];
            st_d.mon_t = bmo[4];
            st_d.mon_o = bmo[3:0];
            st_d.day_t = bd[5:4];
            st_d.day_o = bd[3:0];
        end
        if (wday_load_i) begin
            st_d.wday = wday_i;
        end else if (carry_i) begin
            st_d.wday = (st_q.wday >= WDAY_LAST) ? 3'd0 : st_q.wday + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DATE_RST;
        else        st_q <= st_d;
    end

    assign date_q_o = st_q;
    assign date_d_o = st_d;

endmodule

// File: rtl/bcdclk_alarm.sv
module bcdclk_alarm
    import bcdclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv_i,
    input  logic [29:0] alarm_i,
    input  clk_time_t   cur_time_i,
    input  clk_time_t   nxt_time_i,
    input  logic [5:0]  cur_day_i,
    input  logic [5:0]  nxt_day_i,
    output logic        pulse_o
);

    logic pulse_d, pulse_q;

    function automatic logic hit(input clk_time_t t, input logic [5:0] day, input logic [29:0] a);
        logic [3:0] en;
        en = a[29:26];
        return (|en)
            && (!en[0] || (a[6:0]   == {t.sec_t, t.sec_o}))
            && (!en[1] || (a[13:7]  == {t.min_t, t.min_o}))
            && (!en[2] || (a[19:14] == {t.hr_t,  t.hr_o}))
            && (!en[3] || (a[25:20] == day));
    endfunction

    always_comb begin
        pulse_d = adv_i
               && hit(nxt_time_i, nxt_day_i, alarm_i)
               && !hit(cur_time_i, cur_day_i, alarm_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= pulse_d;
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import bcdclk_pkg::*;
#(
    parameter int WEEK_LEN = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        run_en_i,
    input  logic        hr12_i,
    input  logic        upd_en_i,
    input  logic        upd_sec_i,
    input  logic        time_load_i,
    input  logic [23:0] time_set_i,
    input  logic        date_load_i,
    input  logic [19:0] date_set_i,
    input  logic [29:0] alarm_set_i,
    output logic [31:0] time_word_o,
    output logic [31:0] date_word_o,
    output logic        pm_o,
    output logic        alarm_pulse_o,
    output logic        update_pulse_o
);

    clk_time_t tm_q, tm_d;
    clk_date_t dt_q, dt_d;
    clk_top_t  st_d, st_q;
    logic      step, sec_wrap, day_carry, adv;

    assign step = tick_i && run_en_i;
    assign adv  = step && !time_load_i && !date_load_i;

    bcdclk_time_ctr u_time (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step),
        .load_i      (time_load_i),
        .set_i       ({time_set_i[23], time_set_i[19:0]}),
        .hr12_i      (hr12_i),
        .time_q_o    (tm_q),
        .time_d_o    (tm_d),
        .sec_wrap_o  (sec_wrap),
        .day_carry_o (day_carry)
    );

    bcdclk_date_ctr #(.WEEK_LEN(WEEK_LEN)) u_date (
        .clk         (clk),
        .rst_n       (rst_n),
        .carry_i     (day_carry),
        .load_i      (date_load_i),
        .set_i       (date_set_i),
        .wday_load_i (time_load_i),
        .wday_i      (time_set_i[22:20]),
        .date_q_o    (dt_q),
        .date_d_o    (dt_d)
    );

    bcdclk_alarm u_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .alarm_i    (alarm_set_i),
        .cur_time_i (tm_q),
        .nxt_time_i (tm_d),
        .cur_day_i  ({dt_q.day_t, dt_q.day_o}),
        .nxt_day_i  ({dt_d.day_t, dt_d.day_o}),
        .pulse_o    (alarm_pulse_o)
    );

    always_comb begin
        st_d = st_q;
        if (time_load_i) st_d.t_inv = 1'b0;
        if (date_load_i) st_d.d_inv = 1'b0;
        st_d.upd = upd_en_i && step && !time_load_i && (upd_sec_i || sec_wrap);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{t_inv: 1'b1, d_inv: 1'b1, upd: 1'b0};
        else        st_q <= st_d;
    end

    assign time_word_o = {st_q.t_inv, 8'h00, dt_q.wday, tm_q.hr_t, tm_q.hr_o,
                          tm_q.min_t, tm_q.min_o, tm_q.sec_t, tm_q.sec_o};
    assign date_word_o = {st_q.d_inv, 11'h000, dt_q.cent, dt_q.yr_t, dt_q.yr_o,
                          dt_q.mon_t, dt_q.mon_o, dt_q.day_t, dt_q.day_o};
    assign pm_o           = tm_q.pm;
    assign update_pulse_o = st_q.upd;

endmodule

// File: rtl/bcdclk_checker.sv
module bcdclk_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_i,
    input logic        run_en_i,
    input logic        upd_en_i,
    input logic        upd_sec_i,
    input logic        time_load_i,
    input logic        date_load_i,
    input logic [31:0] time_word_o,
    input logic [31:0] date_word_o,
    input logic        alarm_pulse_o,
    input logic        update_pulse_o
);

    p_alarm_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse_o |=> !alarm_pulse_o);

    p_alarm_after_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse_o |-> $past(tick_i && run_en_i && !time_load_i && !date_load_i));

    p_update_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        update_pulse_o |-> $past(upd_en_i && tick_i && run_en_i));

    p_minute_update_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (update_pulse_o && !$past(upd_sec_i)) |-> (time_word_o[6:0] == 7'h00));

    p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en_i && !time_load_i && !date_load_i) |=> ($stable(time_word_o) && $stable(date_word_o)));

    p_time_valid_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !time_word_o[31] |=> !time_word_o[31]);

    p_date_valid_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !date_word_o[31] |=> !date_word_o[31]);

endmodule

bind bcd_calendar_clock bcdclk_checker u_chk (.*);

// File: tb/tb_bcd_calendar_clock.sv
module tb_bcd_calendar_clock;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0, run_en_i = 1'b0, hr12_i = 1'b0, upd_en_i = 1'b0, upd_sec_i = 1'b0;
    logic        time_load_i = 1'b0, date_load_i = 1'b0;
    logic [23:0] time_set_i = '0;
    logic [19:0] date_set_i = '0;
    logic [29:0] alarm_set_i = '0;
    logic [31:0] time_word_o, date_word_o;
    logic        pm_o, alarm_pulse_o, update_pulse_o;

    always #5 clk = ~clk;

    bcd_calendar_clock dut (.*);

    typedef struct {
        int          due;
        logic [31:0] tw;
        logic [31:0] dw;
        logic        pm;
        logic        al;
        logic        up;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;

    // reference state, binary
    int sec = 0, mnt = 0, hr = 0, pm = 0, wd = 0, dy = 1, mo = 1, yr = 0, ce = 0;
    bit tv = 0, dv = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [23:0] mk_t(input int h, input int m, input int s, input int w, input int p);
        logic [7:0] bh, bm, bs;
        bh = bcd(h); bm = bcd(m); bs = bcd(s);
        return {1'(p), 3'(w), bh[5:0], bm[6:0], bs[6:0]};
    endfunction

    function automatic logic [19:0] mk_d(input int d, input int m, input int y, input int c);
        logic [7:0] bd, bm, by;
        bd = bcd(d); bm = bcd(m); by = bcd(y);
        return {1'(c), by, bm[4:0], bd[5:0]};
    endfunction

    function automatic logic [29:0] mk_a(input logic [3:0] en, input int d, input int h, input int m, input int s);
        logic [7:0] bd, bh, bm, bs;
        bd = bcd(d); bh = bcd(h); bm = bcd(m); bs = bcd(s);
        return {en, bd[5:0], bh[5:0], bm[6:0], bs[6:0]};
    endfunction

    function automatic logic [31:0] ref_tw();
        logic [23:0] t;
        t = mk_t(hr, mnt, sec, wd, 0);
        return {!tv, 8'h00, t[22:0]};
    endfunction

    function automatic logic [31:0] ref_dw();
        return {!dv, 11'h000, mk_d(dy, mo, yr, ce)};
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic bit ref_match();
        logic [31:0] t, d;
        t = ref_tw(); d = ref_dw();
        if (alarm_set_i[29:26] == 4'b0) return 0;
        if (alarm_set_i[26] && alarm_set_i[6:0]   != t[6:0])   return 0;
        if (alarm_set_i[27] && alarm_set_i[13:7]  != t[13:7])  return 0;
        if (alarm_set_i[28] && alarm_set_i[19:14] != t[19:14]) return 0;
        if (alarm_set_i[29] && alarm_set_i[25:20] != d[5:0])   return 0;
        return 1;
    endfunction

    // one cycle of stimulus plus the expected result one edge later
    task automatic drive(input bit lt, input logic [23:0] tset, input bit ld, input logic [19:0] dset,
                         input bit tk, input string tag);
        exp_t e;
        bit   tadv, dc, m_old, m_new;
        @(negedge clk);
        time_load_i = lt; time_set_i = tset;
        date_load_i = ld; date_set_i = dset;
        tick_i = tk;
        tadv  = run_en_i && tk && !lt;
        m_old = ref_match();
        dc    = 0;
        if (lt) begin
            sec = int'(tset[6:4]) * 10 + int'(tset[3:0]);
            mnt = int'(tset[13:11]) * 10 + int'(tset[10:7]);
            hr  = int'(tset[19:18]) * 10 + int'(tset[17:14]);
            wd  = int'(tset[22:20]);
            pm  = int'(tset[23]);
            tv  = 1;
        end else if (tadv) begin
            if (sec >= 59) begin
                sec = 0;
                if (mnt >= 59) begin
                    mnt = 0;
                    if (hr12_i) begin
                        if (hr >= 12) hr = 1;
                        else if (hr == 11) begin hr = 12; dc = (pm != 0); pm = 1 - pm; end
                        else hr = hr + 1;
                    end else begin
                        if (hr >= 23) begin hr = 0; dc = 1; end
                        else hr = hr + 1;
                    end
                end else mnt = mnt + 1;
            end else sec = sec + 1;
        end
        if (dc) wd = (wd >= 6) ? 0 : wd + 1;
        if (ld) begin
            dy = int'(dset[5:4]) * 10 + int'(dset[3:0]);
            mo = int'(dset[10]) * 10 + int'(dset[9:6]);
            yr = int'(dset[18:15]) * 10 + int'(dset[14:11]);
            ce = int'(dset[19]);
            dv = 1;
        end else if (dc) begin
            if (dy >= mdays(mo, yr)) begin
                dy = 1;
                if (mo >= 12) begin
                    mo = 1;
                    if (yr >= 99) begin yr = 0; ce = 1 - ce; end
                    else yr = yr + 1;
                end else mo = mo + 1;
            end else dy = dy + 1;
        end
        m_new = ref_match();
        e.due = cyc + 1;
        e.tw  = ref_tw();
        e.dw  = ref_dw();
        e.pm  = 1'(pm);
        e.al  = tadv && !ld && m_new && !m_old;
        e.up  = upd_en_i && tadv && (upd_sec_i || sec == 0);
        e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        #1;
        time_load_i = 0; date_load_i = 0; tick_i = 0;
    endtask

    task automatic tick(input string tag);
        drive(0, '0, 0, '0, 1, tag);
    endtask

    // monitor: compares each expected item on the negedge after its edge
    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0 && q[0].due == cyc) begin
            e = q.pop_front();
            n_cmp++;
            if (time_word_o !== e.tw || date_word_o !== e.dw || pm_o !== e.pm ||
                alarm_pulse_o !== e.al || update_pulse_o !== e.up) begin
                n_bad++;
                $display("FAIL %s: got t=%h d=%h pm=%b al=%b up=%b exp t=%h d=%h pm=%b al=%b up=%b",
                         e.tag, time_word_o, date_word_o, pm_o, alarm_pulse_o, update_pulse_o,
                         e.tw, e.dw, e.pm, e.al, e.up);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no end, exp end of run");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_cmp++;
        if (time_word_o !== 32'h8000_0000 || date_word_o !== 32'h8000_0041) begin
            n_bad++;
            $display("FAIL R1 reset: got t=%h d=%h exp t=80000000 d=80000041", time_word_o, date_word_o);
        end
        run_en_i = 1;

        // R1 R2: load both words, invalid flags clear
        drive(1, mk_t(23, 59, 58, 6, 0), 1, mk_d(28, 2, 24, 0), 0, "R1 R2 load");
        tick("R4 seconds");
        tick("R5 R7 R9 leap midnight");
        tick("R4 after midnight");

        // R7 common-year February, 30-day month
        drive(1, mk_t(23, 59, 59, 3, 0), 1, mk_d(28, 2, 23, 0), 0, "R2 load");
        tick("R7 Feb 28 common");
        drive(1, mk_t(23, 59, 59, 5, 0), 1, mk_d(30, 4, 23, 0), 0, "R2 load");
        tick("R7 Apr 30");

        // R8 year and century
        drive(1, mk_t(23, 59, 59, 6, 0), 1, mk_d(31, 12, 99, 0), 0, "R2 load");
        tick("R8 R9 century set");
        drive(1, mk_t(23, 59, 59, 2, 0), 1, mk_d(31, 12, 99, 1), 0, "R2 load");
        tick("R8 century clear");
        drive(1, mk_t(10, 9, 59, 2, 0), 0, '0, 0, "R2 load");
        tick("R4 minute tens");

        // R3 idle tick, R2 load wins over tick
        run_en_i = 0;
        tick("R3 run off");
        run_en_i = 1;
        drive(1, mk_t(5, 5, 5, 2, 0), 0, '0, 1, "R2 load over tick");

        // R6 twelve-hour format
        hr12_i = 1;
        drive(1, mk_t(11, 59, 59, 1, 0), 1, mk_d(1, 1, 0, 0), 0, "R2 load");
        tick("R6 noon");
        drive(1, mk_t(11, 59, 59, 1, 1), 0, '0, 0, "R2 load");
        tick("R6 midnight");
        drive(1, mk_t(12, 59, 59, 1, 0), 0, '0, 0, "R2 load");
        tick("R6 12 to 01");
        hr12_i = 0;

        // R10 alarm
        alarm_set_i = mk_a(4'b0011, 0, 0, 20, 30);
        drive(1, mk_t(10, 20, 28, 1, 0), 1, mk_d(5, 1, 0, 0), 0, "R2 load");
        tick("R10 before");
        tick("R10 match");
        tick("R10 after");
        alarm_set_i = mk_a(4'b0000, 5, 10, 20, 33);
        tick("R10 no enable");
        tick("R10 no enable");
        tick("R10 no enable");
        alarm_set_i = mk_a(4'b1000, 6, 0, 0, 0);
        drive(1, mk_t(23, 59, 58, 1, 0), 0, '0, 0, "R2 load");
        tick("R10 day before");
        tick("R10 day match");
        tick("R10 day held");
        alarm_set_i = '0;

        // R11 update pulses
        upd_en_i = 1; upd_sec_i = 1;
        tick("R11 per second");
        tick("R11 per second");
        upd_sec_i = 0;
        drive(1, mk_t(0, 0, 58, 1, 0), 0, '0, 0, "R2 load");
        tick("R11 minute none");
        tick("R11 minute edge");
        tick("R11 minute none");
        upd_en_i = 0;
        drive(1, mk_t(0, 1, 59, 1, 0), 0, '0, 0, "R2 load");
        tick("R11 disabled");

        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule